// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads a directory held in memory and, for small pages, a second-level table. A requester presents a virtual address, an access kind and a privilege flag. The walker fetches the entries through a single-outstanding memory port. It checks the entry flags against the access, writes back the usage flags it must set, and then returns a physical address together with the final entry's low attribute bits, or a fault with a bit-coded cause.

Each directory entry selects its own mapping size. An entry with the large-page flag maps a 4 MB region directly. Otherwise the entry points to a table of 4 KB page entries. The walker serves one request at a time and holds `busy` from the moment it accepts a request until it responds. Its memory requests follow a hold-until-acknowledge handshake.

Top module: `ptw_walker`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` is high and the walker is idle. Its first memory access is a read of the directory entry at `{dir_base, vaddr[31:22], 2'b00}`.
- R2: For a small-page walk, the second read is the table entry at `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R3: An entry whose present bit (bit 0) is clear, at either level, ends the walk with a fault. Error code bit 0 is clear in that case, and no memory write is made.
- R4: A present directory entry with bit 7 set ends the walk at the first level. The physical address is `{dir_entry[31:22], vaddr[21:0]}`.
- R5: For a small page, the physical address is `{table_entry[31:12], vaddr[11:0]}`. On success, `rsp_attr` returns bits 11..0 of the final entry as updated by the walk.
- R6: Bit 2 of an entry grants user access and bit 1 grants writes. A user-mode access needs bit 2 set at every level used, and a user-mode write also needs bit 1 set at every level used. Supervisor accesses are never refused for these flags. A refused access faults with error code bit 0 set.
- R7: The error code has these bits: bit 1 set for a write, bit 2 set for a user-mode access, bit 4 set for an instruction fetch, and bit 3 always clear. The code is all zero on success. Access kinds are encoded as 0 = read, 1 = write, 2 = fetch.
- R8: On success, the walker sets bit 5 (accessed) in every entry it used that lacks it. On a write, it also sets bit 6 (dirty) in the final entry. Entries needing no change are not written. All writes complete before the response.
- R9: Bits 9..11 of an entry have no effect on the outcome, and any update of the entry leaves them unchanged.
- R10: `busy` is high from the cycle after acceptance until the response. `rsp_valid` is a single-cycle pulse with `busy` low. A memory request keeps its address, direction and data stable until `mem_ack`. No memory request is issued while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| dir_base | input | 20 | Frame number of the directory |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | One-cycle acknowledge of the current access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 5 | Fault cause bits |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_attr | output | 12 | Final entry bits 11..0 after update |

## Verification
Several rules are checked by the assertions on every cycle:
- the memory handshake: requests held stable until acknowledged, nothing issued while idle;
- a first access that is always a read;
- a single-cycle response with `busy` low;
- a clear reserved code bit, and a zero code on success;
- write-backs that always carry the present and accessed bits.

Other behaviour only the bench scenarios can show, because it depends on memory contents:
- the address arithmetic at both levels;
- the choice between large and small mappings;
- permission merging across levels and the supervisor bypass;
- the exact set of entries that are rewritten.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int CODE_W = 5;

  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_PS = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_TBL,
    ST_UPD_DIR,
    ST_UPD_TBL,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int OFS_W = 12,
  localparam int AW = 2 * IDX_W + OFS_W,
  localparam int FW = AW - OFS_W
) (
  input  logic [FW-1:0] base,
  input  logic [AW-1:0] va,
  input  logic [FW-1:0] dir_frame,
  input  logic [FW-1:0] tbl_frame,
  output logic [AW-1:0] dir_addr,
  output logic [AW-1:0] tbl_addr,
  output logic [AW-1:0] pa_large,
  output logic [AW-1:0] pa_small
);
  localparam int EB = OFS_W - IDX_W;

  assign dir_addr = {base, va[AW-1 -: IDX_W], {EB{1'b0}}};
  assign tbl_addr = {dir_frame, va[AW-IDX_W-1 -: IDX_W], {EB{1'b0}}};
  assign pa_large = {dir_frame[FW-1 -: IDX_W], va[AW-IDX_W-1:0]};
  assign pa_small = {tbl_frame, va[OFS_W-1:0]};
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic              dir_rw,
  input  logic              dir_us,
  input  logic              fin_rw,
  input  logic              fin_us,
  input  logic              is_wr,
  input  logic              is_fetch,
  input  logic              user,
  output logic              viol,
  output logic [CODE_W-1:0] code_np,
  output logic [CODE_W-1:0] code_pv
);
  logic user_ok, write_ok;

  always_comb begin
    user_ok  = !user || (dir_us && fin_us);
    write_ok = !(user && is_wr) || (dir_rw && fin_rw);
    viol     = !(user_ok && write_ok);
    code_np  = {is_fetch, 1'b0, user, is_wr, 1'b0};
    code_pv  = {is_fetch, 1'b0, user, is_wr, 1'b1};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFS_W = 12,
  localparam int AW = 2 * IDX_W + OFS_W,
  localparam int FW = AW - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [FW-1:0]     dir_base,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code,
  output logic [AW-1:0]     rsp_paddr,
  output logic [OFS_W-1:0]  rsp_attr
);
  walk_state_e state;
  logic [AW-1:0] va_q, pde_q, pte_q;
  logic [FW-1:0] base_q;
  logic [1:0]    kind_q;
  logic          user_q, large_q, tbl_upd_q;

  logic          is_wr, is_fetch;
  logic [AW-1:0] va_src, dir_src, flag_a, flag_ad, new_ent;
  logic [FW-1:0] base_src;
  logic [AW-1:0] dir_addr, tbl_addr, pa_large, pa_small;
  logic          viol;
  logic [CODE_W-1:0] code_np, code_pv;

  always_comb begin
    is_wr    = (kind_q == ACC_WRITE);
    is_fetch = (kind_q == ACC_FETCH);
    va_src   = (state == ST_IDLE) ? req_vaddr : va_q;
    base_src = (state == ST_IDLE) ? dir_base : base_q;
    dir_src  = (state == ST_DIR) ? mem_rdata : pde_q;
    flag_a   = '0;
    flag_a[BIT_A] = 1'b1;
    flag_ad  = flag_a;
    flag_ad[BIT_D] = is_wr;
    new_ent  = mem_rdata | flag_ad;
  end

  ptw_addr_gen #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
    .base      (base_src),
    .va        (va_src),
    .dir_frame (dir_src[AW-1:OFS_W]),
    .tbl_frame (mem_rdata[AW-1:OFS_W]),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr),
    .pa_large  (pa_large),
    .pa_small  (pa_small)
  );

  ptw_perm_chk u_perm (
    .dir_rw   (dir_src[BIT_RW]),
    .dir_us   (dir_src[BIT_US]),
    .fin_rw   (mem_rdata[BIT_RW]),
    .fin_us   (mem_rdata[BIT_US]),
    .is_wr    (is_wr),
    .is_fetch (is_fetch),
    .user     (user_q),
    .viol     (viol),
    .code_np  (code_np),
    .code_pv  (code_pv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
      rsp_attr  <= '0;
      va_q      <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      base_q    <= '0;
      kind_q    <= 2'd0;
      user_q    <= 1'b0;
      large_q   <= 1'b0;
      tbl_upd_q <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            base_q   <= dir_base;
            kind_q   <= req_kind;
            user_q   <= req_user;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_addr;
            state    <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            large_q <= mem_rdata[BIT_PS];
            if (!mem_rdata[BIT_P]) begin
              mem_req   <= 1'b0;
              rsp_fault <= 1'b1;
              rsp_code  <= code_np;
              state     <= ST_RESP;
            end else if (mem_rdata[BIT_PS]) begin
              pde_q     <= new_ent;
              rsp_paddr <= pa_large;
              rsp_attr  <= new_ent[OFS_W-1:0];
              if (viol) begin
                mem_req   <= 1'b0;
                rsp_fault <= 1'b1;
                rsp_code  <= code_pv;
                state     <= ST_RESP;
              end else if (new_ent != mem_rdata) begin
                mem_we    <= 1'b1;
                mem_addr  <= dir_addr;
                mem_wdata <= new_ent;
                rsp_fault <= 1'b0;
                rsp_code  <= '0;
                state     <= ST_UPD_DIR;
              end else begin
                mem_req   <= 1'b0;
                rsp_fault <= 1'b0;
                rsp_code  <= '0;
                state     <= ST_RESP;
              end
            end else begin
              pde_q    <= mem_rdata;
              mem_addr <= tbl_addr;
              state    <= ST_TBL;
            end
          end
        end
        ST_TBL: begin
          if (mem_ack) begin
            pte_q     <= new_ent;
            tbl_upd_q <= (new_ent != mem_rdata);
            rsp_paddr <= pa_small;
            rsp_attr  <= new_ent[OFS_W-1:0];
            if (!mem_rdata[BIT_P] || viol) begin
              mem_req   <= 1'b0;
              rsp_fault <= 1'b1;
              rsp_code  <= mem_rdata[BIT_P] ? code_pv : code_np;
              state     <= ST_RESP;
            end else begin
              rsp_fault <= 1'b0;
              rsp_code  <= '0;
              if (!pde_q[BIT_A]) begin
                pde_q     <= pde_q | flag_a;
                mem_we    <= 1'b1;
                mem_addr  <= dir_addr;
                mem_wdata <= pde_q | flag_a;
                state     <= ST_UPD_DIR;
              end else if (new_ent != mem_rdata) begin
                mem_we    <= 1'b1;
                mem_addr  <= tbl_addr;
                mem_wdata <= new_ent;
                state     <= ST_UPD_TBL;
              end else begin
                mem_req <= 1'b0;
                state   <= ST_RESP;
              end
            end
          end
        end
        ST_UPD_DIR: begin
          if (mem_ack) begin
            if (!large_q && tbl_upd_q) begin
              mem_addr  <= tbl_addr;
              mem_wdata <= pte_q;
              state     <= ST_UPD_TBL;
            end else begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              state   <= ST_RESP;
            end
          end
        end
        ST_UPD_TBL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          rsp_valid <= 1'b1;
          busy      <= 1'b0;
          mem_we    <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [AW-1:0]     mem_wdata,
  input logic              mem_ack,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [CODE_W-1:0] rsp_code
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_req); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R10
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> !busy && !mem_req); // R10
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> mem_req && !mem_we); // R1
  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]); // R8
  AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_code == '0); // R7
  AST_RSV_BIT: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> !rsp_code[3]); // R7
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW), .CODE_W(ptw_pkg::CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_code  (rsp_code)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_user = 1'b0;
  logic [19:0] dir_base = '0;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [4:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_attr;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .dir_base(dir_base), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr)
  );

  // memory model: 4096 words, directory at frame 0, tables at frames 1..3
  logic [31:0] mem [0:4095];
  logic [1:0]  lat;
  logic        bw_en = 1'b0;
  logic [11:0] bw_idx = '0;
  logic [31:0] bw_dat = '0;
  int          n_writes = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      lat       <= 2'd0;
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
    end else begin
      if (bw_en) mem[bw_idx] <= bw_dat;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (lat == 2'd0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[13:2]];
          if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            n_writes <= n_writes + 1;
          end
          lat <= 2'($urandom % 3);
        end else lat <= lat - 2'd1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    bw_en = 1'b1; bw_idx = 12'(idx); bw_dat = val;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  function automatic void ref_walk(input logic [31:0] va, input logic [1:0] k, input logic u,
      output logic f, output logic [4:0] c, output logic [31:0] pa, output logic [11:0] at,
      output logic [31:0] npde, output logic [31:0] npte, output int pi, output logic lg,
      output int nw);
    logic [31:0] d, t;
    logic wr, fe, us_ok, rw_ok;
    wr = (k == 2'd1);
    fe = (k == 2'd2);
    d = mem[{2'b00, va[31:22]}];
    pi = {d[13:12], va[21:12]};
    t = mem[pi];
    npde = d; npte = t; f = 1'b0; c = '0; pa = '0; at = '0; nw = 0;
    lg = d[7];
    if (!d[0] || (!lg && !t[0])) begin
      f = 1'b1; c = {fe, 1'b0, u, wr, 1'b0};
      return;
    end
    us_ok = !u || (d[2] && (lg ? d[2] : t[2]));
    rw_ok = !(u && wr) || (d[1] && (lg ? d[1] : t[1]));
    if (!(us_ok && rw_ok)) begin
      f = 1'b1; c = {fe, 1'b0, u, wr, 1'b1};
      return;
    end
    if (lg) begin
      npde = d | 32'h20 | (wr ? 32'h40 : 32'h0);
      pa = {d[31:22], va[21:0]};
      at = npde[11:0];
    end else begin
      npde = d | 32'h20;
      npte = t | 32'h20 | (wr ? 32'h40 : 32'h0);
      pa = {t[31:12], va[11:0]};
      at = npte[11:0];
      nw = (npte != t) ? 1 : 0;
    end
    nw += (npde != d) ? 1 : 0;
  endfunction

  task automatic run(input logic [31:0] va, input logic [1:0] k, input logic u);
    logic ef, lg; logic [4:0] ec; logic [31:0] epa, npde, npte, old_pte; logic [11:0] eat;
    int pi, nw, w0, n;
    ref_walk(va, k, u, ef, ec, epa, eat, npde, npte, pi, lg, nw);
    old_pte = mem[pi];
    w0 = n_writes;
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    check(rsp_valid === 1'b1, "R10 response arrives", 32'(rsp_valid), 32'd1);
    check(busy === 1'b0, "R10 busy low at response", 32'(busy), 32'd0);
    check(rsp_fault === ef, "R3 R6 fault flag", 32'(rsp_fault), 32'(ef));
    check(rsp_code === ec, "R7 error code", 32'(rsp_code), 32'(ec));
    if (!ef) begin
      check(rsp_paddr === epa, "R1 R2 R4 R5 physical address", rsp_paddr, epa);
      check(rsp_attr === eat, "R5 R9 attributes", 32'(rsp_attr), 32'(eat));
    end
    check(mem[{2'b00, va[31:22]}] === npde, "R8 R9 directory entry after walk",
          mem[{2'b00, va[31:22]}], npde);
    if (!lg) check(mem[pi] === (ef ? old_pte : npte), "R8 R9 table entry after walk",
                   mem[pi], ef ? old_pte : npte);
    check(n_writes - w0 == nw, "R3 R8 number of write-backs", 32'(n_writes - w0), 32'(nw));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 response is one cycle", 32'(rsp_valid), 32'd0);
  endtask

  // dir entry at di, table entry for va using table frame tf
  task automatic setup(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
    poke({2'b00, va[31:22]}, pde);
    if (!pde[7]) poke({pde[13:12], va[21:12]}, pte);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && rsp_valid === 1'b0 && mem_req === 1'b0, "R10 reset state",
          {29'd0, busy, rsp_valid, mem_req}, 32'd0);

    // directory entry missing (R3)
    setup(32'h0140_0123, 32'h0000_0000, 32'h0);
    run(32'h0140_0123, 2'd1, 1'b1);
    // table entry missing (R3)
    setup(32'h0280_5abc, 32'h0000_1027, 32'h1234_5026);
    run(32'h0280_5abc, 2'd0, 1'b0);
    // large page, accessed clear, supervisor read (R4 R8)
    setup(32'h0c12_3456, 32'hab40_0083, 32'h0);
    run(32'h0c12_3456, 2'd0, 1'b0);
    // large page user write, full rights, dirty set (R4 R8)
    setup(32'h0d3f_fffc, 32'h5c80_0087, 32'h0);
    run(32'h0d3f_fffc, 2'd1, 1'b1);
    // small page user write, both levels writable (R2 R5 R8)
    setup(32'h1004_5678, 32'h0000_2007, 32'hfeed_c007);
    run(32'h1004_5678, 2'd1, 1'b1);
    // user write, directory read-only: protection fault code 00111 (R6 R7)
    setup(32'h1108_9000, 32'h0000_3065, 32'h1111_1067);
    run(32'h1108_9000, 2'd1, 1'b1);
    // supervisor write to read-only page succeeds (R6)
    setup(32'h1200_0fff, 32'h0000_1021, 32'h2222_2021);
    run(32'h1200_0fff, 2'd1, 1'b0);
    // user fetch of supervisor page: code 10101 (R6 R7)
    setup(32'h1300_1004, 32'h0000_2027, 32'h3333_3063);
    run(32'h1300_1004, 2'd2, 1'b1);
    // ignored bits 9..11 kept, already-used flags: no writes (R9 R8)
    setup(32'h1400_2008, 32'h0000_3e27, 32'h4444_4e67);
    run(32'h1400_2008, 2'd1, 1'b1);
    // large page fault: user on supervisor directory (R4 R6)
    setup(32'h1500_0000, 32'h7740_0083, 32'h0);
    run(32'h1500_0000, 2'd0, 1'b1);

    for (int t = 0; t < 400; t++) begin
      logic [31:0] va, pde, pte;
      logic [19:0] fr;
      va = $urandom;
      pde = $urandom;
      pte = $urandom;
      pde[0] = ($urandom % 8) != 0;
      pte[0] = ($urandom % 8) != 0;
      pde[7] = ($urandom % 3) == 0;
      pte[7] = 1'b0;
      if (!pde[7]) begin
        fr = 20'(1 + ($urandom % 3));
        pde[31:12] = fr;
      end
      setup(va, pde, pte);
      run(va, 2'($urandom % 3), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule